// File: doc/BRIEF.md
# Significance-Grouping Bit Permuter

This block sits in the data path of a memory controller, between a 32-bit application word and a 32-bit DRAM data bus. The bus is built from four chips, each 8 bits wide. On the write path it reorders the word so that bits of the same weight from every value packed in the word end up in the same chip. The top chip therefore holds only the most significant slices and the bottom chip only the least significant ones. Each chip can then be refreshed at a rate that matches the importance of what it stores. The read path applies the exact inverse, so software always sees the original word.

A 2-bit mode picks the grouping to match the data type. Mode 0 is plain pass-through for critical data, mode 1 groups bytes, mode 2 groups 16-bit halfwords, and mode 3 treats the word as a single 32-bit value. The mode is normally taken from a few high physical-address bits. The write and read directions each have their own mode input, and the two are used independently. Both permutation networks are combinational. An output register stage is included when the parameter `OUT_REG` is 1 (the default), which gives each direction a latency of one cycle.

Top module: `sig_bit_permuter`

## Requirements
- R1: While `rst_n` is low, with `OUT_REG`=1, both `dram_wdata` and `app_rdata` read 0.
- R2: In mode 0, `dram_wdata` equals `app_wdata` and `app_rdata` equals `dram_rdata`.
- R3: In mode 1 (bytes), bits 2j and 2j+1 of chip 0 (bus bits 7..0) carry bits 0 and 1 of byte j, for j = 0..3.
- R4: In mode 1, chip k bit 2j+b (bus bit 8k+2j+b) carries bit 2k+b of byte j, for every chip k and b in {0,1}. Chip 3 therefore holds bits 7..6 of all four bytes.
- R5: In mode 2 (halfwords), chip k bit 4j+b carries bit 4k+b of halfword j, for j in {0,1} and b = 0..3. Chip 3 therefore holds bits 15..12 of both halfwords.
- R6: In mode 3 (one 32-bit value), chip k takes bits 8k+7..8k, so the bus equals the input word.
- R7: The read path applies the inverse of the write mapping for `app_rmode`. Writing a word in any mode and reading it back in the same mode returns that word exactly.
- R8: With `OUT_REG`=1, each output reflects the inputs sampled at the previous rising clock edge. The write and read directions run at the same time, each under its own mode.
- R9: In mode 1, a single flipped bit in chip 3 of the read bus changes exactly one byte of `app_rdata`, by 64 or 128. A single flipped bit in chip 0 changes exactly one byte, by 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| app_wmode | input | 2 | Grouping mode for the write path |
| app_wdata | input | 32 | Application word to be written |
| dram_wdata | output | 32 | Permuted word for the DRAM bus, chip k on bits 8k+7..8k |
| app_rmode | input | 2 | Grouping mode for the read path |
| dram_rdata | input | 32 | Word read from the DRAM bus |
| app_rdata | output | 32 | Restored application word |

## Verification
With the output stage present, both directions are due one cycle after their inputs are applied. The bench drives a new stimulus on each falling edge. At the next falling edge it compares each output against the value that a behavioural reference model computed from the previous stimulus. The result is therefore taken once the capturing rising edge has passed and before the next stimulus is applied. The round-trip and single-bit-error cases feed a bus word that the bench computed itself into the read path, and score the result in the cycle that follows.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int MODE_W    = 2;
    localparam int NUM_MODES = 1 << MODE_W;

    typedef enum logic [MODE_W-1:0] {
        GRP_PASS = 2'd0,
        GRP_BYTE = 2'd1,
        GRP_HALF = 2'd2,
        GRP_WORD = 2'd3
    } grp_mode_e;

    // width of one packed value under a grouping mode
    function automatic int elem_width(input int mode, input int nc, input int cw);
        if (mode == int'(GRP_BYTE)) return cw;
        if (mode == int'(GRP_HALF)) return 2 * cw;
        return nc * cw;
    endfunction

    // application bit that feeds bus bit d under a grouping mode
    function automatic int src_bit(input int mode, input int d, input int nc, input int cw);
        int e;
        int s;
        int k;
        int p;
        if (mode == int'(GRP_PASS)) return d;
        e = elem_width(mode, nc, cw);
        s = e / nc;
        k = d / cw;
        p = d % cw;
        return (p / s) * e + k * s + (p % s);
    endfunction

endpackage

// File: rtl/sp_lane_net.sv
module sp_lane_net #(
    parameter int NC      = 4,
    parameter int CW      = 8,
    parameter bit INVERSE = 1'b0
) (
    input  logic [sp_pkg::MODE_W-1:0] mode,
    input  logic [NC*CW-1:0]          din,
    output logic [NC*CW-1:0]          dout
);
    localparam int DW = NC * CW;
    localparam int NM = sp_pkg::NUM_MODES;

    logic [NM-1:0][DW-1:0] alt;

    for (genvar m = 0; m < NM; m++) begin : g_mode
        for (genvar d = 0; d < DW; d++) begin : g_bit
            localparam int SRC = sp_pkg::src_bit(m, d, NC, CW);
            if (INVERSE) begin : g_gather
                assign alt[m][SRC] = din[d];
            end else begin : g_scatter
                assign alt[m][d] = din[SRC];
            end
        end
    end

    assign dout = alt[mode];

endmodule

// File: rtl/sig_bit_permuter.sv
module sig_bit_permuter #(
    parameter int NUM_CHIPS = 4,
    parameter int CHIP_W    = 8,
    parameter bit OUT_REG   = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [sp_pkg::MODE_W-1:0] app_wmode,
    input  logic [NUM_CHIPS*CHIP_W-1:0] app_wdata,
    output logic [NUM_CHIPS*CHIP_W-1:0] dram_wdata,
    input  logic [sp_pkg::MODE_W-1:0] app_rmode,
    input  logic [NUM_CHIPS*CHIP_W-1:0] dram_rdata,
    output logic [NUM_CHIPS*CHIP_W-1:0] app_rdata
);
    localparam int DW = NUM_CHIPS * CHIP_W;
    localparam int SB = CHIP_W / NUM_CHIPS;
    localparam int SH = 2 * CHIP_W / NUM_CHIPS;
    localparam int TOP = (NUM_CHIPS - 1) * CHIP_W;

    typedef struct packed {
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } stage_t;

    logic [DW-1:0] wr_perm;
    logic [DW-1:0] rd_perm;
    stage_t        stage_d;
    stage_t        stage_q;

    sp_lane_net #(.NC(NUM_CHIPS), .CW(CHIP_W), .INVERSE(1'b0)) u_wr_net (
        .mode (app_wmode),
        .din  (app_wdata),
        .dout (wr_perm)
    );

    sp_lane_net #(.NC(NUM_CHIPS), .CW(CHIP_W), .INVERSE(1'b1)) u_rd_net (
        .mode (app_rmode),
        .din  (dram_rdata),
        .dout (rd_perm)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.wdata = wr_perm;
        stage_d.rdata = rd_perm;
    end

    if (OUT_REG) begin : g_reg
        logic armed_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
                armed_q <= 1'b0;
            end else begin
                stage_q <= stage_d;
                armed_q <= 1'b1;
            end
        end

        // R1: outputs clear while reset is held
        p_reset_clear_r1: assert property (@(posedge clk)
            !rst_n |=> (dram_wdata == '0 && app_rdata == '0));

        // R2: pass-through mode in both directions, one cycle later (R8)
        p_pass_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(app_wmode) == sp_pkg::GRP_PASS) |-> dram_wdata == $past(app_wdata));
        p_pass_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(app_rmode) == sp_pkg::GRP_PASS) |-> app_rdata == $past(dram_rdata));

        // R6: single 32-bit value lands in natural order
        p_word_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(app_wmode) == sp_pkg::GRP_WORD) |-> dram_wdata == $past(app_wdata));

        for (genvar j = 0; j < NUM_CHIPS; j++) begin : g_byte_chk
            // R3: low weight bits of every byte in chip 0
            p_byte_chip0_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && $past(app_wmode) == sp_pkg::GRP_BYTE) |->
                dram_wdata[j*SB +: SB] == $past(app_wdata[j*CHIP_W +: SB]));
            // R4: high weight bits of every byte in the top chip
            p_byte_chip3_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && $past(app_wmode) == sp_pkg::GRP_BYTE) |->
                dram_wdata[TOP + j*SB +: SB] == $past(app_wdata[j*CHIP_W + CHIP_W - SB +: SB]));
        end

        for (genvar j = 0; j < 2; j++) begin : g_half_chk
            // R5: top slice of each halfword in the top chip
            p_half_chip3_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && $past(app_wmode) == sp_pkg::GRP_HALF) |->
                dram_wdata[TOP + j*SH +: SH] == $past(app_wdata[j*2*CHIP_W + 2*CHIP_W - SH +: SH]));
        end
    end else begin : g_comb
        assign stage_q = stage_d;
    end

    assign dram_wdata = stage_q.wdata;
    assign app_rdata  = stage_q.rdata;

endmodule

// File: tb/sim_sig_bit_permuter.sv
module sim_sig_bit_permuter;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [1:0]  app_wmode;
    logic [31:0] app_wdata;
    logic [31:0] dram_wdata;
    logic [1:0]  app_rmode;
    logic [31:0] dram_rdata;
    logic [31:0] app_rdata;

    int n_checks;
    int n_errors;
    int cycles;

    sig_bit_permuter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .app_wmode  (app_wmode),
        .app_wdata  (app_wdata),
        .dram_wdata (dram_wdata),
        .app_rmode  (app_rmode),
        .dram_rdata (dram_rdata),
        .app_rdata  (app_rdata)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    // bus position of application bit i under mode m
    function automatic int dest_of(input int m, input int i);
        int e;
        int s;
        int r;
        if (m == 0) return i;
        e = (m == 1) ? 8 : (m == 2) ? 16 : 32;
        s = e / 4;
        r = i % e;
        return (r / s) * 8 + (i / e) * s + (r % s);
    endfunction

    function automatic logic [31:0] fwd_ref(input int m, input logic [31:0] w);
        logic [31:0] o;
        o = '0;
        for (int i = 0; i < 32; i++) o[dest_of(m, i)] = w[i];
        return o;
    endfunction

    function automatic logic [31:0] inv_ref(input int m, input logic [31:0] x);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) o[i] = x[dest_of(m, i)];
        return o;
    endfunction

    // pending expectations for the next sample
    logic [31:0] exp_w, exp_r, orig_w;
    string       tag_w, tag_r;
    bit          chk9;
    int          chip9;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic score_r9();
        int nz;
        int diff;
        int a;
        int b;
        nz = 0;
        diff = 0;
        for (int j = 0; j < 4; j++) begin
            a = int'(app_rdata[8*j +: 8]);
            b = int'(orig_w[8*j +: 8]);
            if (a != b) begin
                nz++;
                diff = (a > b) ? a - b : b - a;
            end
        end
        n_checks++;
        if (nz != 1 ||
            (chip9 == 3 && diff != 64 && diff != 128) ||
            (chip9 == 0 && diff != 1 && diff != 2)) begin
            n_errors++;
            $display("FAIL R9 chip=%0d actual bytes changed=%0d diff=%0d expected 1 byte diff %s",
                     chip9, nz, diff, (chip9 == 3) ? "64/128" : "1/2");
        end
    endtask

    // compare the previous stimulus' results, then apply a new one
    task automatic step(input int wm, input logic [31:0] wd, input string tw,
                        input int rm, input logic [31:0] rd, input string tr);
        @(negedge clk);
        check(tag_w, dram_wdata, exp_w);
        check(tag_r, app_rdata, exp_r);
        if (chk9) score_r9();
        chk9      = 1'b0;
        app_wmode = 2'(wm);
        app_wdata = wd;
        app_rmode = 2'(rm);
        dram_rdata = rd;
        exp_w = fwd_ref(wm, wd);
        exp_r = inv_ref(rm, rd);
        tag_w = {tw, " R8"};
        tag_r = {tr, " R8"};
    endtask

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=%0d cycles expected completion", cycles);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] w;
        n_checks = 0;
        n_errors = 0;
        chk9 = 1'b0;
        rst_n = 1'b0;
        app_wmode = '0;
        app_wdata = '0;
        app_rmode = '0;
        dram_rdata = '0;
        exp_w = '0;
        exp_r = '0;
        tag_w = "R1 wr";
        tag_r = "R1 rd";

        // R1: inputs move but reset holds outputs at zero
        repeat (3) begin
            @(negedge clk);
            check("R1 reset wr", dram_wdata, 32'h0);
            check("R1 reset rd", app_rdata, 32'h0);
            app_wdata = $urandom;
            dram_rdata = $urandom;
        end
        @(negedge clk);
        check("R1 reset wr", dram_wdata, 32'h0);
        check("R1 reset rd", app_rdata, 32'h0);
        rst_n = 1'b1;
        app_wmode = '0;
        app_wdata = '0;
        dram_rdata = '0;

        // R2: pass-through
        step(0, 32'hDEADBEEF, "R2 wr", 0, 32'h12345678, "R2 rd");
        step(0, 32'h80000001, "R2 wr", 0, 32'hFFFF0000, "R2 rd");

        // R3/R4: byte grouping, walking-one and patterns
        for (int i = 0; i < 32; i++)
            step(1, 32'h1 << i, (i % 8 < 2) ? "R3 byte" : "R4 byte", 1, 32'h1 << i, "R7 byte inv");
        step(1, 32'hC0C0C0C0, "R4 byte top", 2, 32'hA5A5A5A5, "R7 half inv");
        step(1, 32'h03030303, "R3 byte low", 3, 32'h5A5A5A5A, "R7 word inv");

        // R5: halfword grouping
        for (int i = 0; i < 32; i++)
            step(2, 32'h1 << i, "R5 half", 2, 32'h1 << i, "R7 half inv");
        step(2, 32'hF000F000, "R5 half top", 1, 32'h0F0F0F0F, "R7 byte inv");

        // R6: whole-word grouping
        step(3, 32'hCAFEF00D, "R6 word", 0, 32'h0BADC0DE, "R2 rd");
        step(3, 32'h00FF00FF, "R6 word", 3, 32'h00FF00FF, "R6 rd");

        // random mixed modes, write and read independent
        for (int i = 0; i < 200; i++)
            step(i % 4, $urandom, "R8 mix wr", (i / 4) % 4, $urandom, "R7 mix rd");

        // R7: round trip in every mode
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 8; i++) begin
                w = $urandom;
                step(m, w, "R7 rt wr", m, fwd_ref(m, w), "R7 roundtrip");
                check("R7 roundtrip ref", inv_ref(m, fwd_ref(m, w)), w);
            end
        end

        // R9: single-bit error bound in byte mode
        for (int c = 0; c < 4; c += 3) begin
            for (int b = 0; b < 8; b++) begin
                w = $urandom;
                step(1, w, "R4 byte", 1, fwd_ref(1, w) ^ (32'h1 << (8*c + b)), "R7 byte inv");
                chk9 = 1'b1;
                chip9 = c;
                orig_w = w;
            end
        end

        step(0, 32'h0, "R2 wr", 0, 32'h0, "R2 rd");
        @(negedge clk);
        check(tag_w, dram_wdata, exp_w);
        check(tag_r, app_rdata, exp_r);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule